// File: doc/BRIEF.md
# Glitch-Free Clock Source Selector

This block picks one of five incoming clocks and forwards it as the clock of one downstream domain. Software chooses the source by writing a 3-bit code into a configuration register that lives in the register clock domain. The codes, in order, are: 0 the slow real-time oscillator, 1 the main crystal oscillator, 2 the first PLL, 3 the second PLL and 4 the third PLL. After reset the crystal oscillator is selected.

A change of source is a two-step handshake. First the enable of the old source is withdrawn. That enable is synchronized into the old clock and takes effect while that clock is low. The block waits until the loss of the enable is confirmed back in the register domain. Only then is the enable of the new source raised. It is synchronized into the new clock, takes effect while that clock is low, and is confirmed back in the register domain. While this runs, a read-only busy bit in the register reads 1, and software polls it until it reads 0.

A build parameter can lock the domain to source 4. In that variant every write is refused, and the register always reports code 4 and not busy.

Top module: `clk_src_mux`

## Requirements
- R1: After reset the register reads 0x00000001, which is code 1 with busy at 0. The output clock follows source 1.
- R2: A write of a valid code (0 to 4) that differs from the current one moves the output clock to the source with that code once the switch completes. The order of codes is: 0 real-time oscillator, 1 crystal, 2 to 4 the three PLLs.
- R3: A write whose low three bits hold 5, 6 or 7 is ignored. The selection and the output clock stay as they were.
- R4: Register bit 3 reads 1 from the first clock edge after a write that starts a switch. It returns to 0 only after the new source's enable has been confirmed in the register domain.
- R5: The output never shows a high or low pulse shorter than half the period of the sources involved. At no time are two sources confirmed as enabled together.
- R6: Writing the code that is already selected starts no switch, and bit 3 stays 0.
- R7: A write affects only bits [2:0]. Bit 3 is read-only, and bits [31:4] always read 0 whatever data is written.
- R8: With the lock parameter set, the register always reads code 4 with busy at 0. Writes have no effect, and the output follows source 4.
- R9: A write that arrives while a switch is in progress is ignored. The switch already under way completes to its own target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset, shared by all domains |
| src_clk | input | NUM_SRC | Candidate clocks, indexed by code |
| cfg_we | input | 1 | Register write strobe, sampled on clk |
| cfg_wdata | input | REG_W | Register write data; only bits [2:0] are used |
| cfg_rdata | output | REG_W | Register read value: bit 3 busy, bits [2:0] selection |
| clk_out | output | 1 | Selected, glitch-free domain clock |

## Verification
The hardest case to reach from the ports is a second write landing inside the window of an ongoing switch. The bench issues two writes on consecutive register cycles, so the second one falls in the drop phase. It then checks that the first target wins, both in the register readback and in the measured output period. Glitch freedom is watched all the time by a monitor that records the narrowest high and low pulse seen on the output over every switch. The switches include ones between the slowest and fastest sources, where an early start would produce a short pulse.

// File: rtl/clk_src_mux_pkg.sv
package clk_src_mux_pkg;

   // phases of one source change
   typedef enum logic [1:0] {
      SW_IDLE  = 2'd0,
      SW_DROP  = 2'd1,
      SW_RAISE = 2'd2
   } sw_state_e;

endpackage

// File: rtl/clk_src_mux_gate.sv
// Per-source enable path: request synchronized into the source clock,
// applied at the low phase, confirmation synchronized back.
module clk_src_mux_gate #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RST_ON      = 1'b0
) (
   input  logic rst_n,
   input  logic reg_clk,
   input  logic src_clk,
   input  logic en_req,
   output logic gated_clk,
   output logic ack
);

   localparam int unsigned TOP = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] fwd_q;
   logic                   gate_q;
   logic [SYNC_STAGES-1:0] back_q;

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) fwd_q <= {SYNC_STAGES{RST_ON}};
      else        fwd_q <= {fwd_q[SYNC_STAGES-2:0], en_req};
   end

   // gate only changes while the source is low
   always_ff @(negedge src_clk or negedge rst_n) begin
      if (!rst_n) gate_q <= RST_ON;
      else        gate_q <= fwd_q[TOP];
   end

   always_ff @(posedge reg_clk or negedge rst_n) begin
      if (!rst_n) back_q <= {SYNC_STAGES{RST_ON}};
      else        back_q <= {back_q[SYNC_STAGES-2:0], gate_q};
   end

   assign gated_clk = src_clk & gate_q;
   assign ack       = back_q[TOP];

   AST_ACK_NEEDS_REQ: assert property (@(posedge reg_clk) disable iff (!rst_n)
      $rose(ack) |-> en_req); // R5

endmodule

// File: rtl/clk_src_mux_ctrl.sv
// Register field and switch sequencer in the register clock domain.
module clk_src_mux_ctrl
   import clk_src_mux_pkg::*;
#(
   parameter int unsigned NUM_SRC    = 5,
   parameter int unsigned SEL_W      = 3,
   parameter int unsigned RESET_CODE = 1,
   parameter bit          LOCKED     = 1'b0,
   parameter int unsigned LOCK_CODE  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SEL_W-1:0]   wr_sel,
   input  logic [NUM_SRC-1:0] ack,
   output logic [NUM_SRC-1:0] en_req,
   output logic [SEL_W-1:0]   rd_sel,
   output logic               rd_busy
);

   localparam logic [NUM_SRC-1:0] ONE_HOT0 = NUM_SRC'(1);

   if ((1 << SEL_W) < NUM_SRC) begin : g_bad_width
      $error("SEL_W too narrow for NUM_SRC");
   end
   if (LOCK_CODE >= NUM_SRC || RESET_CODE >= NUM_SRC) begin : g_bad_code
      $error("reset or lock code out of range");
   end

   if (LOCKED) begin : g_fixed
      logic unused_fixed_in;
      assign unused_fixed_in = wr_en ^ (^wr_sel) ^ (^ack);
      assign en_req  = ONE_HOT0 << LOCK_CODE;
      assign rd_sel  = SEL_W'(LOCK_CODE);
      assign rd_busy = 1'b0;
   end else begin : g_switch
      sw_state_e          st_q;
      logic [SEL_W-1:0]   cur_q;
      logic [SEL_W-1:0]   tgt_q;
      logic [NUM_SRC-1:0] req_q;
      logic               code_ok;
      logic               start;

      assign code_ok = (int'(wr_sel) < NUM_SRC);
      assign start   = wr_en && (st_q == SW_IDLE) && code_ok && (wr_sel != cur_q);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q  <= SW_IDLE;
            cur_q <= SEL_W'(RESET_CODE);
            tgt_q <= SEL_W'(RESET_CODE);
            req_q <= ONE_HOT0 << RESET_CODE;
         end else begin
            case (st_q)
               SW_IDLE: if (start) begin
                  tgt_q <= wr_sel;
                  req_q <= '0;
                  st_q  <= SW_DROP;
               end
               SW_DROP: if (!ack[cur_q]) begin
                  req_q <= ONE_HOT0 << tgt_q;
                  st_q  <= SW_RAISE;
               end
               SW_RAISE: if (ack[tgt_q]) begin
                  cur_q <= tgt_q;
                  st_q  <= SW_IDLE;
               end
               default: st_q <= SW_IDLE;
            endcase
         end
      end

      assign en_req  = req_q;
      assign rd_sel  = tgt_q;
      assign rd_busy = (st_q != SW_IDLE);

      AST_SWITCH_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !rd_busy && int'(wr_sel) < NUM_SRC && wr_sel != rd_sel) |=> rd_busy); // R4
      AST_DONE_CONFIRMED: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(rd_busy) |-> ack[rd_sel]); // R4
      AST_SAME_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !rd_busy && wr_sel == rd_sel) |=> !rd_busy); // R6
      AST_BAD_CODE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && int'(wr_sel) >= NUM_SRC) |=> $stable(rd_sel)); // R3
      AST_BUSY_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && rd_busy) |=> $stable(rd_sel)); // R9
      AST_BREAK_BEFORE_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(ack)); // R5
   end

endmodule

// File: rtl/clk_src_mux.sv
module clk_src_mux #(
   parameter int unsigned NUM_SRC     = 5,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned REG_W       = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RESET_CODE  = 1,
   parameter bit          LOCKED      = 1'b0,
   parameter int unsigned LOCK_CODE   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_clk,
   input  logic               cfg_we,
   input  logic [REG_W-1:0]   cfg_wdata,
   output logic [REG_W-1:0]   cfg_rdata,
   output logic               clk_out
);

   localparam int unsigned BUSY_BIT   = SEL_W;
   localparam int unsigned START_CODE = LOCKED ? LOCK_CODE : RESET_CODE;

   if (REG_W < SEL_W + 2) begin : g_bad_reg
      $error("REG_W too narrow");
   end

   logic [NUM_SRC-1:0] en_req;
   logic [NUM_SRC-1:0] ack;
   logic [NUM_SRC-1:0] gated;
   logic [SEL_W-1:0]   rd_sel;
   logic               rd_busy;
   logic               unused_wdata_hi;

   assign unused_wdata_hi = ^cfg_wdata[REG_W-1:SEL_W];

   clk_src_mux_ctrl #(
      .NUM_SRC   (NUM_SRC),
      .SEL_W     (SEL_W),
      .RESET_CODE(RESET_CODE),
      .LOCKED    (LOCKED),
      .LOCK_CODE (LOCK_CODE)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we),
      .wr_sel (cfg_wdata[SEL_W-1:0]),
      .ack    (ack),
      .en_req (en_req),
      .rd_sel (rd_sel),
      .rd_busy(rd_busy)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      clk_src_mux_gate #(
         .SYNC_STAGES(SYNC_STAGES),
         .RST_ON     (i == START_CODE)
      ) u_gate (
         .rst_n    (rst_n),
         .reg_clk  (clk),
         .src_clk  (src_clk[i]),
         .en_req   (en_req[i]),
         .gated_clk(gated[i]),
         .ack      (ack[i])
      );
   end

   assign clk_out   = |gated;
   assign cfg_rdata = REG_W'({rd_busy, rd_sel});

   if (LOCKED) begin : g_lock_chk
      AST_LOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(cfg_rdata[SEL_W-1:0]) == LOCK_CODE) && !cfg_rdata[BUSY_BIT]); // R8
   end

endmodule

// File: tb/clk_src_mux_test.sv
`timescale 1ns/1ps
module clk_src_mux_test;

   localparam real REG_HALF = 2.5;
   localparam real PER [5] = '{30.0, 14.0, 8.0, 10.0, 12.0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  src_clk = '0;
   logic        we_m = 1'b0, we_f = 1'b0;
   logic [31:0] wd_m = '0, wd_f = '0;
   logic [31:0] rd_m, rd_f;
   logic        co_m, co_f;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(REG_HALF) clk = ~clk;
   for (genvar g = 0; g < 5; g++) begin : g_clk
      initial forever #(PER[g] / 2.0) src_clk[g] = ~src_clk[g];
   end

   clk_src_mux uut (
      .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .cfg_we(we_m),
      .cfg_wdata(wd_m), .cfg_rdata(rd_m), .clk_out(co_m));

   clk_src_mux #(.LOCKED(1'b1), .LOCK_CODE(4)) uut_fix (
      .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .cfg_we(we_f),
      .cfg_wdata(wd_f), .cfg_rdata(rd_f), .clk_out(co_f));

   // scoreboard for register reads
   typedef struct {
      bit          fix;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb_q[$];
   event  sb_ev;

   always begin
      @(sb_ev);
      while (sb_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it  = sb_q.pop_front();
         act = it.fix ? rd_f : rd_m;
         tests++;
         if (act !== it.exp) begin
            fails++;
            $display("FAIL %s: register actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic expect_reg(input bit fix, input logic [31:0] exp, input string tag);
      sb_q.push_back('{fix, exp, tag});
      ->sb_ev;
      #0.1;
   endtask

   task automatic wr(input bit fix, input logic [31:0] d);
      @(negedge clk);
      if (fix) begin we_f = 1'b1; wd_f = d; end
      else     begin we_m = 1'b1; wd_m = d; end
      @(negedge clk);
      we_f = 1'b0; we_m = 1'b0;
   endtask

   task automatic wait_idle(input string tag);
      for (int n = 0; n < 5000; n++) begin
         if (!rd_m[3]) return;
         @(negedge clk);
      end
      tests++; fails++;
      $display("FAIL %s: busy actual 1 expected 0 after 5000 cycles", tag);
   endtask

   task automatic check_period(input bit fix, input int code, input string tag);
      realtime t0, t1;
      for (int k = 0; k < 3; k++) begin
         if (fix) @(posedge co_f); else @(posedge co_m);
      end
      t0 = $realtime;
      if (fix) @(posedge co_f); else @(posedge co_m);
      t1 = $realtime;
      tests++;
      if ((t1 - t0) < PER[code] - 0.01 || (t1 - t0) > PER[code] + 0.01) begin
         fails++;
         $display("FAIL %s: period actual %0.3f expected %0.3f", tag, t1 - t0, PER[code]);
      end
   endtask

   // pulse width monitor on the switching instance
   realtime t_rise = 0.0, t_fall = 0.0;
   realtime min_hi = 1.0e9, min_lo = 1.0e9;
   bit seen_rise = 1'b0, seen_fall = 1'b0;
   always @(posedge co_m) begin
      if (seen_fall && (($realtime - t_fall) < min_lo)) min_lo = $realtime - t_fall;
      t_rise = $realtime; seen_rise = 1'b1;
   end
   always @(negedge co_m) begin
      if (seen_rise && (($realtime - t_rise) < min_hi)) min_hi = $realtime - t_rise;
      t_fall = $realtime; seen_fall = 1'b1;
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      #900000;
      tests++; fails++;
      $display("FAIL watchdog: run actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      expect_reg(1'b0, 32'h0000_0001, "R1 reset value");
      check_period(1'b0, 1, "R1 reset source");

      // R2/R4/R7 switch to code 3 with junk upper bits
      wr(1'b0, 32'hFFFF_FFF3);
      expect_reg(1'b0, 32'h0000_000B, "R4 busy after write / R7 upper bits");
      wait_idle("R4 busy clears");
      expect_reg(1'b0, 32'h0000_0003, "R7 only low bits written");
      check_period(1'b0, 3, "R2 switched to code 3");

      // R6 same code
      wr(1'b0, 32'h0000_0003);
      expect_reg(1'b0, 32'h0000_0003, "R6 same code no busy");
      @(negedge clk);
      expect_reg(1'b0, 32'h0000_0003, "R6 still idle");

      // R3 invalid codes
      wr(1'b0, 32'h0000_0006);
      expect_reg(1'b0, 32'h0000_0003, "R3 code 6 ignored");
      wr(1'b0, 32'h0000_0007);
      expect_reg(1'b0, 32'h0000_0003, "R3 code 7 ignored");
      check_period(1'b0, 3, "R3 output kept");

      // R9 write while busy: 2 then 4 back to back
      @(negedge clk);
      we_m = 1'b1; wd_m = 32'h2;
      @(negedge clk);
      wd_m = 32'h4;
      @(negedge clk);
      we_m = 1'b0;
      wait_idle("R9 busy clears");
      expect_reg(1'b0, 32'h0000_0002, "R9 second write ignored");
      check_period(1'b0, 2, "R9 first target wins");

      // R2 slowest and back
      wr(1'b0, 32'h0);
      wait_idle("R2 to code 0");
      expect_reg(1'b0, 32'h0000_0000, "R2 code 0 readback");
      check_period(1'b0, 0, "R2 code 0 source");
      wr(1'b0, 32'h4);
      wait_idle("R2 to code 4");
      check_period(1'b0, 4, "R2 code 4 source");
      wr(1'b0, 32'h1);
      wait_idle("R2 to code 1");
      check_period(1'b0, 1, "R2 code 1 source");

      // R8 locked variant
      expect_reg(1'b1, 32'h0000_0004, "R8 locked reset read");
      wr(1'b1, 32'h0000_0001);
      expect_reg(1'b1, 32'h0000_0004, "R8 locked write refused");
      check_period(1'b1, 4, "R8 locked source");

      // R5 pulse widths over all switches
      tests++;
      if (min_hi < 3.99 || min_lo < 3.99) begin
         fails++;
         $display("FAIL R5: narrowest pulse actual hi %0.3f lo %0.3f expected >= 4.000",
                  min_hi, min_lo);
      end

      finish_run();
   end

endmodule